// File: doc/BRIEF.md
# Serial ADC Host Sequencer

This block is the host-side controller for a 12-bit serial analog-to-digital converter that times its own conversion. When a request is accepted it drops chip select and shifts out an 8-bit command word built from the configured channel, polarity, input mode and power-down setting. It then releases chip select and keeps the serial clock low while the converter works. The converter reports that it is busy through a strobe input that falls when the conversion starts and rises when it ends.

After the synchronized strobe has been seen low and then high, the block lowers chip select again and clocks in the 12 result bits, most significant bit first. It returns them with a one-cycle valid pulse and goes back to idle. If the strobe does not finish within a configurable number of clock cycles, the block gives up, pulses a timeout flag and returns to idle without producing a sample. The serial clock period is set by a divider parameter, so the readback rate can be kept under the converter's limit.

Top module: `sadc_host_seq`

## Requirements
- R1: The command word goes out on `mosi` most significant bit first: bit 7 = 1 (start), bits 6..4 = `cfgChan`, bit 3 = `cfgUnipolar`, bit 2 = `cfgSingle`, bits 1..0 = `cfgPower`. Each bit is set up while `sclk` is low and stays stable while `sclk` is high, over 8 rising edges with `csN` low. `mosi` is 0 outside the command phase.
- R2: `reqReady` is high only in idle. A request is taken on a rising clock edge where both `reqValid` and `reqReady` are high. `reqValid` has no effect at any other time. The configuration inputs are captured when the request is accepted, and later changes do not alter the transfer in progress.
- R3: From the end of the eighth command bit until readback begins, `csN` is high and `sclk` is low. Readback does not start until the synchronized strobe has been seen low and then high.
- R4: The strobe passes through two flip-flops. When `convStrobe` rises between two clock edges, `csN` falls on the third rising clock edge after that change.
- R5: Readback uses 12 serial clock periods. Each period is a high phase and then a low phase. The falling edge at the end of the first high phase presents the MSB. `miso` is sampled on the clock edge where `sclk` rises at the end of each low phase. The 12 samples are assembled MSB first into `sampleData`.
- R6: `sampleValid` is high for exactly one cycle, the cycle after the last bit is sampled, and `sampleData` holds the result during that cycle. In the next cycle `csN` is high, `sclk` is low and `reqReady` is high.
- R7: The wait for the strobe starts when the command ends and is limited to `TMO_LIMIT` clock cycles. If the strobe has not completed its low-then-high sequence in that time, `timeoutErr` pulses for one cycle in the first idle cycle, no `sampleValid` is produced and no readback clock is issued.
- R8: Every command and readback `sclk` phase, high or low, lasts `HALF_DIV` clock cycles. The only exception is the single-cycle closing high level in the cycle that `sampleValid` marks.
- R9: During and right after reset, `csN` = 1, `sclk` = 0, `mosi` = 0, `reqReady` = 1, `sampleValid` = 0 and `timeoutErr` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request to run one conversion |
| reqReady | output | 1 | High while idle and able to accept a request |
| cfgChan | input | 3 | Channel select field of the command word |
| cfgUnipolar | input | 1 | Polarity field: 1 = unipolar |
| cfgSingle | input | 1 | Input mode field: 1 = single-ended |
| cfgPower | input | 2 | Power-down field of the command word |
| csN | output | 1 | Active-low chip select to the converter |
| sclk | output | 1 | Serial clock to the converter |
| mosi | output | 1 | Command data to the converter |
| miso | input | 1 | Result data from the converter |
| convStrobe | input | 1 | Busy strobe from the converter: low while converting |
| sampleValid | output | 1 | One-cycle pulse marking a new result |
| sampleData | output | 12 | Conversion result |
| timeoutErr | output | 1 | One-cycle pulse when the strobe wait times out |

## Verification
The hardest case to reach from the ports is a timeout that fires after the strobe has already fallen but before it rises. The sequencer is then partway through the wait, and the strobe must not be allowed to rise later and start a readback. The bench's converter model holds the strobe low for longer than the limit and raises it only once the block is idle again. A following transfer then shows that the late strobe was ignored. A second hard case is a request held high across two back-to-back transfers while the configuration changes mid-transfer. Here the per-cycle reference model shows that only idle cycles accept requests and that the command word comes from the values seen at acceptance.

// File: rtl/sadc_pkg.sv
`timescale 1ns/1ps
package sadc_pkg;

  localparam int CMD_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD_LO,
    ST_CMD_HI,
    ST_WAIT_LO,
    ST_WAIT_HI,
    ST_RD_HI,
    ST_RD_LO,
    ST_DONE
  } seqState_t;

  // strobes from the controller to the datapath
  typedef struct packed {
    logic loadCmd;
    logic shiftCmd;
    logic sampleBit;
    logic phaseClr;
    logic bitClr;
    logic bitStep;
    logic tmoClr;
    logic sclkNext;
    logic csNNext;
    logic validNext;
    logic tmoNext;
  } seqCtl_t;

  // command word: start, channel, polarity, input mode, power-down
  function automatic logic [CMD_W-1:0] packCmd(input logic [2:0] chan,
                                               input logic       unipolar,
                                               input logic       single,
                                               input logic [1:0] power);
    return {1'b1, chan, unipolar, single, power};
  endfunction

endpackage

// File: rtl/sadc_sync.sv
`timescale 1ns/1ps
module sadc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rstN,
  input  logic asyncIn,
  output logic syncOut
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain <= {STAGES{RST_VAL}};
    else       chain <= {chain[STAGES-2:0], asyncIn};
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/sadc_ctrl.sv
`timescale 1ns/1ps
module sadc_ctrl
  import sadc_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    strobeSync,
  input  logic    halfDone,
  input  logic    lastCmdBit,
  input  logic    lastDataBit,
  input  logic    tmoHit,
  output logic    reqReady,
  output seqCtl_t ctl
);

  seqState_t stateQ, stateD;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

  assign reqReady = (stateQ == ST_IDLE);

  always_comb begin
    stateD        = stateQ;
    ctl           = '0;
    ctl.phaseClr  = 1'b1;
    ctl.tmoClr    = 1'b1;
    ctl.csNNext   = 1'b1;
    ctl.sclkNext  = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        if (reqValid) begin
          ctl.loadCmd = 1'b1;
          ctl.bitClr  = 1'b1;
          ctl.csNNext = 1'b0;
          stateD      = ST_CMD_LO;
        end
      end
      ST_CMD_LO: begin
        ctl.csNNext = 1'b0;
        if (halfDone) begin
          ctl.sclkNext = 1'b1;
          stateD       = ST_CMD_HI;
        end else begin
          ctl.phaseClr = 1'b0;
        end
      end
      ST_CMD_HI: begin
        ctl.csNNext = 1'b0;
        if (halfDone) begin
          ctl.shiftCmd = 1'b1;
          if (lastCmdBit) begin
            ctl.csNNext = 1'b1;
            stateD      = ST_WAIT_LO;
          end else begin
            ctl.bitStep = 1'b1;
            stateD      = ST_CMD_LO;
          end
        end else begin
          ctl.phaseClr = 1'b0;
          ctl.sclkNext = 1'b1;
        end
      end
      ST_WAIT_LO: begin
        ctl.tmoClr = 1'b0;
        if (!strobeSync) begin
          stateD = ST_WAIT_HI;
        end else if (tmoHit) begin
          ctl.tmoNext = 1'b1;
          stateD      = ST_IDLE;
        end
      end
      ST_WAIT_HI: begin
        ctl.tmoClr = 1'b0;
        if (strobeSync) begin
          ctl.csNNext  = 1'b0;
          ctl.sclkNext = 1'b1;
          ctl.bitClr   = 1'b1;
          stateD       = ST_RD_HI;
        end else if (tmoHit) begin
          ctl.tmoNext = 1'b1;
          stateD      = ST_IDLE;
        end
      end
      ST_RD_HI: begin
        ctl.csNNext = 1'b0;
        if (halfDone) begin
          stateD = ST_RD_LO;
        end else begin
          ctl.phaseClr = 1'b0;
          ctl.sclkNext = 1'b1;
        end
      end
      ST_RD_LO: begin
        ctl.csNNext = 1'b0;
        if (halfDone) begin
          ctl.sampleBit = 1'b1;
          ctl.sclkNext  = 1'b1;
          if (lastDataBit) begin
            ctl.validNext = 1'b1;
            stateD        = ST_DONE;
          end else begin
            ctl.bitStep = 1'b1;
            stateD      = ST_RD_HI;
          end
        end else begin
          ctl.phaseClr = 1'b0;
        end
      end
      ST_DONE: begin
        stateD = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  // R3: a readback can only be entered from the high-strobe wait
  assert_read_after_wait_R3: assert property (@(posedge clk) disable iff (!rstN)
    (stateD == ST_RD_HI && stateQ != ST_RD_LO && stateQ != ST_RD_HI)
      |-> (stateQ == ST_WAIT_HI && strobeSync));

endmodule

// File: rtl/sadc_dpath.sv
`timescale 1ns/1ps
module sadc_dpath
  import sadc_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int HALF_DIV  = 50,
  parameter int TMO_LIMIT = 1000
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic              misoIn,
  output logic              halfDone,
  output logic              lastCmdBit,
  output logic              lastDataBit,
  output logic              tmoHit,
  output logic              sclkQ,
  output logic              csNQ,
  output logic              mosiOut,
  output logic              validQ,
  output logic              tmoQ,
  output logic [DATA_W-1:0] resultQ
);

  localparam int MAX_BITS = (DATA_W > CMD_W) ? DATA_W : CMD_W;
  localparam int HALF_W   = $clog2(HALF_DIV + 1);
  localparam int BIT_W    = $clog2(MAX_BITS + 1);
  localparam int TMO_W    = $clog2(TMO_LIMIT + 1);

  logic [HALF_W-1:0] halfCnt;
  logic [BIT_W-1:0]  bitCnt;
  logic [TMO_W-1:0]  tmoCnt;
  logic [CMD_W-1:0]  cmdSr;
  logic [DATA_W-1:0] resSr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      halfCnt <= '0;
      bitCnt  <= '0;
      tmoCnt  <= '0;
      cmdSr   <= '0;
      resSr   <= '0;
      sclkQ   <= 1'b0;
      csNQ    <= 1'b1;
      validQ  <= 1'b0;
      tmoQ    <= 1'b0;
    end else begin
      halfCnt <= ctl.phaseClr ? '0 : halfCnt + 1'b1;
      if (ctl.bitClr)       bitCnt <= '0;
      else if (ctl.bitStep) bitCnt <= bitCnt + 1'b1;
      tmoCnt <= ctl.tmoClr ? '0 : tmoCnt + 1'b1;
      if (ctl.loadCmd)       cmdSr <= cmdWord;
      else if (ctl.shiftCmd) cmdSr <= {cmdSr[CMD_W-2:0], 1'b0};
      if (ctl.sampleBit)     resSr <= {resSr[DATA_W-2:0], misoIn};
      sclkQ  <= ctl.sclkNext;
      csNQ   <= ctl.csNNext;
      validQ <= ctl.validNext;
      tmoQ   <= ctl.tmoNext;
    end
  end

  assign halfDone    = (halfCnt == HALF_W'(HALF_DIV - 1));
  assign lastCmdBit  = (bitCnt == BIT_W'(CMD_W - 1));
  assign lastDataBit = (bitCnt == BIT_W'(DATA_W - 1));
  assign tmoHit      = (tmoCnt == TMO_W'(TMO_LIMIT - 1));
  assign mosiOut     = cmdSr[CMD_W-1];
  assign resultQ     = resSr;

  // R5: a data bit is taken only while the serial clock is low, as it rises
  assert_sample_on_rise_R5: assert property (@(posedge clk) disable iff (!rstN)
    ctl.sampleBit |-> (!sclkQ && !csNQ && ctl.sclkNext));

  // R3: the command register is empty once the command has left
  assert_cmd_drained_R3: assert property (@(posedge clk) disable iff (!rstN)
    (csNQ && !ctl.loadCmd) |-> !mosiOut);

endmodule

// File: rtl/sadc_host_seq.sv
`timescale 1ns/1ps
module sadc_host_seq
  import sadc_pkg::*;
#(
  parameter int DATA_W      = 12,
  parameter int HALF_DIV    = 50,
  parameter int TMO_LIMIT   = 1000,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [2:0]        cfgChan,
  input  logic              cfgUnipolar,
  input  logic              cfgSingle,
  input  logic [1:0]        cfgPower,
  output logic              csN,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  input  logic              convStrobe,
  output logic              sampleValid,
  output logic [DATA_W-1:0] sampleData,
  output logic              timeoutErr
);

  seqCtl_t          ctl;
  logic             strobeSync;
  logic             halfDone, lastCmdBit, lastDataBit, tmoHit;
  logic [CMD_W-1:0] cmdWord;

  assign cmdWord = packCmd(cfgChan, cfgUnipolar, cfgSingle, cfgPower);

  sadc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (convStrobe),
    .syncOut (strobeSync)
  );

  sadc_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .strobeSync  (strobeSync),
    .halfDone    (halfDone),
    .lastCmdBit  (lastCmdBit),
    .lastDataBit (lastDataBit),
    .tmoHit      (tmoHit),
    .reqReady    (reqReady),
    .ctl         (ctl)
  );

  sadc_dpath #(.DATA_W(DATA_W), .HALF_DIV(HALF_DIV), .TMO_LIMIT(TMO_LIMIT)) dpath_i (
    .clk         (clk),
    .rstN        (rstN),
    .ctl         (ctl),
    .cmdWord     (cmdWord),
    .misoIn      (miso),
    .halfDone    (halfDone),
    .lastCmdBit  (lastCmdBit),
    .lastDataBit (lastDataBit),
    .tmoHit      (tmoHit),
    .sclkQ       (sclk),
    .csNQ        (csN),
    .mosiOut     (mosi),
    .validQ      (sampleValid),
    .tmoQ        (timeoutErr),
    .resultQ     (sampleData)
  );

  // R3: with the converter deselected the serial clock rests low
  assert_sclk_rest_R3: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  // R2: ready only while the bus is quiet
  assert_ready_quiet_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (csN && !sclk && !sampleValid));

  // R1: command data never moves while the serial clock is high
  assert_mosi_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && sclk) |-> $stable(mosi));

  // R6: the valid pulse is one cycle wide and the bus closes after it
  assert_valid_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> (!sampleValid && csN && !sclk && reqReady));

  // R7: timeout and result are exclusive, timeout lands in idle
  assert_timeout_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> (!sampleValid && reqReady && csN) ##1 !timeoutErr);

endmodule

// File: tb/sadc_host_seq_tb_top.sv
`timescale 1ns/1ps
module sadc_host_seq_tb_top;

  localparam int HALF = 2;
  localparam int TMO  = 40;
  localparam int DW   = 12;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic [2:0]    cfgChan = '0;
  logic          cfgUnipolar = 1'b0;
  logic          cfgSingle = 1'b0;
  logic [1:0]    cfgPower = '0;
  logic          miso = 1'b0;
  logic          convStrobe = 1'b1;
  logic          reqReady, csN, sclk, mosi, sampleValid, timeoutErr;
  logic [DW-1:0] sampleData;

  int checks = 0;
  int errors = 0;
  bit cmpOn = 1'b0;

  always #2.5 clk = ~clk;

  sadc_host_seq #(.DATA_W(DW), .HALF_DIV(HALF), .TMO_LIMIT(TMO), .SYNC_STAGES(2)) dut_i (
    .clk (clk), .rstN (rstN), .reqValid (reqValid), .reqReady (reqReady),
    .cfgChan (cfgChan), .cfgUnipolar (cfgUnipolar), .cfgSingle (cfgSingle),
    .cfgPower (cfgPower), .csN (csN), .sclk (sclk), .mosi (mosi), .miso (miso),
    .convStrobe (convStrobe), .sampleValid (sampleValid), .sampleData (sampleData),
    .timeoutErr (timeoutErr)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference, advanced on every rising edge
  int         ph, cnt, bits, tmo;   // ph: 0 idle 1 cmd-low 2 cmd-high 3 wait-low 4 wait-high 5 rd-high 6 rd-low 7 done
  logic [7:0] mCmd;
  logic [11:0] mRes;
  logic       s1, s2, eSclk, eCsN, eValid, eTmo;

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ph = 0; cnt = 0; bits = 0; tmo = 0; mCmd = '0; mRes = '0;
      s1 = 1'b1; s2 = 1'b1; eSclk = 1'b0; eCsN = 1'b1; eValid = 1'b0; eTmo = 1'b0;
    end else begin
      eValid = 1'b0;
      eTmo   = 1'b0;
      case (ph)
        0: if (reqValid) begin
             mCmd = {1'b1, cfgChan, cfgUnipolar, cfgSingle, cfgPower};
             bits = 0; cnt = 0; ph = 1; eCsN = 1'b0;
           end
        1: if (cnt == HALF - 1) begin cnt = 0; ph = 2; eSclk = 1'b1; end
           else cnt++;
        2: if (cnt == HALF - 1) begin
             cnt = 0; eSclk = 1'b0;
             if (bits == 7) begin ph = 3; eCsN = 1'b1; tmo = 0; end
             else begin bits++; ph = 1; end
           end else cnt++;
        3: if (!s2) begin ph = 4; tmo++; end
           else if (tmo == TMO - 1) begin ph = 0; eTmo = 1'b1; end
           else tmo++;
        4: if (s2) begin ph = 5; eCsN = 1'b0; eSclk = 1'b1; bits = 0; cnt = 0; end
           else if (tmo == TMO - 1) begin ph = 0; eTmo = 1'b1; end
           else tmo++;
        5: if (cnt == HALF - 1) begin cnt = 0; eSclk = 1'b0; ph = 6; end
           else cnt++;
        6: if (cnt == HALF - 1) begin
             cnt = 0; mRes = {mRes[10:0], miso}; eSclk = 1'b1;
             if (bits == DW - 1) begin ph = 7; eValid = 1'b1; end
             else begin bits++; ph = 5; end
           end else cnt++;
        default: begin ph = 0; eCsN = 1'b1; eSclk = 1'b0; end
      endcase
      s2 = s1;
      s1 = convStrobe;
    end
  end

  // ---------------- compare on every falling edge
  always @(negedge clk) begin
    if (rstN && cmpOn) begin
      logic eMosi;
      eMosi = (ph == 1 || ph == 2) ? mCmd[7 - bits] : 1'b0;
      check(sclk == eSclk, "R8 sclk", int'(sclk), int'(eSclk));
      check(csN == eCsN, "R3 csN", int'(csN), int'(eCsN));
      check(mosi == eMosi, "R1 mosi", int'(mosi), int'(eMosi));
      check(reqReady == (ph == 0), "R2 reqReady", int'(reqReady), int'(ph == 0));
      check(sampleValid == eValid, "R6 sampleValid", int'(sampleValid), int'(eValid));
      check(timeoutErr == eTmo, "R7 timeoutErr", int'(timeoutErr), int'(eTmo));
      if (eValid) check(sampleData == mRes, "R5 sampleData", int'(sampleData), int'(mRes));
    end
  end

  // ---------------- converter model
  task automatic devRun(input logic [11:0] val, input int convDly, input bit respond,
                        input bit expRead, input logic [7:0] expCmd);
    logic [7:0] got = '0;
    @(negedge csN);
    for (int i = 0; i < 8; i++) begin
      @(posedge sclk);
      got = {got[6:0], mosi};
    end
    check(got == expCmd, "R1 command word", int'(got), int'(expCmd));
    if (respond) begin
      repeat (2) @(negedge clk);
      convStrobe = 1'b0;
      repeat (convDly) @(negedge clk);
      convStrobe = 1'b1;
      if (expRead) begin
        repeat (2) @(negedge clk);
        check(csN == 1'b1, "R4 csN before sync", int'(csN), 1);
        @(negedge clk);
        check(csN == 1'b0, "R4 csN after sync", int'(csN), 0);
        for (int i = DW - 1; i >= 0; i--) begin
          @(negedge sclk);
          #1 miso = val[i];
        end
      end
    end
  endtask

  task automatic doXfer(input logic [2:0] ch, input logic u, input logic s, input logic [1:0] p,
                        input logic [11:0] val, input int dly, input bit respond, input bit expRead);
    logic [7:0] ec;
    ec = {1'b1, ch, u, s, p};
    fork
      devRun(val, dly, respond, expRead, ec);
      begin
        bit sawV, sawT;
        @(negedge clk);
        cfgChan = ch; cfgUnipolar = u; cfgSingle = s; cfgPower = p; reqValid = 1'b1;
        @(negedge clk);
        reqValid = 1'b0;
        cfgChan = ~ch; cfgPower = ~p; cfgUnipolar = ~u;   // R2: late change must not matter
        while (!sampleValid && !timeoutErr) @(negedge clk);
        sawV = sampleValid; sawT = timeoutErr;
        if (expRead) begin
          check(sawV && !sawT, "R6 result delivered", int'(sawV), 1);
          check(sampleData == val, "R5 result value", int'(sampleData), int'(val));
          @(negedge clk);
          check(!sampleValid && csN && !sclk && reqReady, "R6 after pulse",
                int'({sampleValid, csN, sclk, reqReady}), int'(4'b0101));
        end else begin
          check(sawT && !sawV, "R7 timeout flagged", int'(sawT), 1);
          check(sclk == 1'b0 && csN == 1'b1, "R7 no readback", int'({sclk, csN}), 1);
        end
      end
    join
  endtask

  // ---------------- watchdog
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  // ---------------- main sequence
  initial begin
    repeat (3) @(negedge clk);
    check(csN == 1'b1 && sclk == 1'b0 && mosi == 1'b0, "R9 reset lines",
          int'({csN, sclk, mosi}), 4);
    check(reqReady && !sampleValid && !timeoutErr, "R9 reset flags",
          int'({reqReady, sampleValid, timeoutErr}), 4);
    rstN = 1'b1;
    cmpOn = 1'b1;
    @(negedge clk);
    check(csN == 1'b1 && reqReady == 1'b1, "R9 after release", int'({csN, reqReady}), 3);

    doXfer(3'd5, 1'b1, 1'b1, 2'd3, 12'hA5C, 10, 1'b1, 1'b1);
    doXfer(3'd2, 1'b0, 1'b0, 2'd0, 12'h001, 20, 1'b1, 1'b1);
    doXfer(3'd7, 1'b1, 1'b0, 2'd1, 12'hFFF, 6, 1'b1, 1'b1);
    // R7: strobe falls but stays low past the limit, rises later while idle
    doXfer(3'd0, 1'b0, 1'b1, 2'd2, 12'h800, 100, 1'b1, 1'b0);
    // R7: strobe never falls at all
    doXfer(3'd3, 1'b1, 1'b1, 2'd0, 12'h000, 0, 1'b0, 1'b0);
    // recovery after timeouts
    doXfer(3'd6, 1'b0, 1'b1, 2'd1, 12'h3C7, 8, 1'b1, 1'b1);

    // R2: request held across two back-to-back transfers, configuration changed mid-flight
    fork
      begin
        devRun(12'h5A3, 8, 1'b1, 1'b1, {1'b1, 3'd1, 1'b0, 1'b1, 2'd2});
        devRun(12'h1E0, 9, 1'b1, 1'b1, {1'b1, 3'd4, 1'b1, 1'b0, 2'd1});
      end
      begin
        @(negedge clk);
        cfgChan = 3'd1; cfgUnipolar = 1'b0; cfgSingle = 1'b1; cfgPower = 2'd2; reqValid = 1'b1;
        @(negedge clk);
        cfgChan = 3'd4; cfgUnipolar = 1'b1; cfgSingle = 1'b0; cfgPower = 2'd1;
        check(reqReady == 1'b0, "R2 busy not ready", int'(reqReady), 0);
        while (!sampleValid) @(negedge clk);
        check(sampleData == 12'h5A3, "R5 first back-to-back", int'(sampleData), 'h5A3);
        @(negedge clk);
        check(reqReady == 1'b1, "R2 idle between transfers", int'(reqReady), 1);
        @(negedge clk);
        reqValid = 1'b0;
        check(reqReady == 1'b0 && csN == 1'b0, "R2 held request accepted",
              int'({reqReady, csN}), 0);
        while (!sampleValid) @(negedge clk);
        check(sampleData == 12'h1E0, "R5 second back-to-back", int'(sampleData), 'h1E0);
      end
    join

    repeat (10) @(negedge clk);
    check(reqReady && csN && !sclk, "R2 quiet at end", int'({reqReady, csN, sclk}), 6);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule